// File: doc/BRIEF.md
# IDE Channel Hidden Configuration Window

This block sits on the target side of an IDE-style channel and watches the host's I/O cycles on the eight task-file port addresses. The channel's timing, control, strap and miscellaneous settings occupy those same addresses. They stay invisible until the host performs a fixed unlock handshake. While the window is closed, every access to the channel is steered to the drive path. While it is open, byte accesses at a few small offsets reach the internal settings instead.

There are two banks of read and write cycle timing values. Bit 0 of the miscellaneous setting selects which bank the timing offsets reach. A special control value splits the banks, so that the first drive runs from bank A and the second drive runs from bank B. The address-setup, ready-timing and prefetch bits in the miscellaneous setting are shared by both drives. The per-drive timing values, the shared setting and the window state are all brought out as ports, so that a bus-cycle generator can consume them.

Top module: `ide_cfgwin`

## Requirements
- R1: After reset the window is closed, all four timing values and the control and miscellaneous settings read 0x00, and bank A (misc bit 0 = 0) is selected.
- R2: The window opens on the clock edge that takes the third of these accesses, made back to back in the channel: a 16-bit read at offset 1, another 16-bit read at offset 1, and a byte write of 0x03 at offset 2.
- R3: During the handshake, any channel access that is not the next expected step returns the sequencer to idle. Examples are a read at another offset, a third read at offset 1, or a write of a value other than 0x03. Accesses outside the channel range leave the sequencer where it is.
- R4: While the window is open, a write of 0x83 at offset 2 closes it on that edge. That write is not forwarded to the drive.
- R5: While the window is closed, every channel access asserts drv_sel and returns drv_rdata on io_rdata. No hidden setting changes.
- R6: While the window is open, accesses at offsets 0, 1, 3, 5 and 6 go to the hidden settings with drv_sel low, and reads return the 8-bit value zero-extended. Offsets 2 (other than the close value), 4 and 7 are still forwarded to the drive.
- R7: Offset 0 (read timing) and offset 1 (write timing) reach bank A when misc bit 0 is 0 and bank B when it is 1, for both reads and writes.
- R8: Offset 5 reads back strap_clk25 in bit 0 (1 = 25 MHz bus, 0 = 33 MHz) with the other bits zero. Writes to it have no effect.
- R9: Drive 0 always uses bank A. Drive 1 uses bank B when the control setting (offset 3) equals 0x85, and bank A otherwise.
- R10: misc_cfg always shows the miscellaneous setting (offset 6), which both drives share.
- R11: An access is in the channel when io_addr with its low 3 bits dropped equals BASE_ADDR with its low 3 bits dropped (default 0x1F0). Accesses outside the channel never assert drv_sel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_valid | input | 1 | Host I/O cycle present this clock |
| io_write | input | 1 | 1 = write, 0 = read |
| io_wide | input | 1 | 1 = 16-bit access, 0 = byte access |
| io_addr | input | ADDR_W (16) | Host I/O address |
| io_wbyte | input | REG_W (8) | Low byte of host write data |
| io_rdata | output | DATA_W (16) | Read data returned to the host |
| drv_sel | output | 1 | Access is steered to the drive path |
| drv_rdata | input | DATA_W (16) | Read data from the drive path |
| strap_clk25 | input | 1 | Board strap: 1 = 25 MHz bus clock |
| window_open | output | 1 | Hidden configuration window is open |
| d0_rd_tim | output | REG_W (8) | Drive 0 read-cycle timing |
| d0_wr_tim | output | REG_W (8) | Drive 0 write-cycle timing |
| d1_rd_tim | output | REG_W (8) | Drive 1 read-cycle timing |
| d1_wr_tim | output | REG_W (8) | Drive 1 write-cycle timing |
| misc_cfg | output | REG_W (8) | Shared setup, ready-timing and prefetch setting |

## Verification
The assertions assume that one host cycle at most is presented per clock and that io_write, io_wide, io_addr and io_wbyte are settled whenever io_valid is high. The same clock edge both captures a write and moves the unlock sequencer. The bench presents each access for exactly one clock, driven on the falling edge. It drops io_valid before the next access, so every handshake step is a separate and well-formed cycle. Accesses outside the channel are mixed into the handshakes to confirm that they do not disturb the sequencer.

// File: rtl/ide_cfgwin_pkg.sv
package ide_cfgwin_pkg;

  localparam int OFF_W     = 3;
  localparam int NUM_BANKS = 2;
  localparam int BANK_W    = $clog2(NUM_BANKS);
  localparam int NUM_DRV   = 2;

  localparam logic [OFF_W-1:0] OFF_TIM_RD = 3'd0;
  localparam logic [OFF_W-1:0] OFF_TIM_WR = 3'd1;
  localparam logic [OFF_W-1:0] OFF_KEY    = 3'd2;
  localparam logic [OFF_W-1:0] OFF_CTRL   = 3'd3;
  localparam logic [OFF_W-1:0] OFF_STRAP  = 3'd5;
  localparam logic [OFF_W-1:0] OFF_MISC   = 3'd6;

  localparam logic [7:0] KEY_OPEN  = 8'h03;
  localparam logic [7:0] KEY_CLOSE = 8'h83;
  localparam logic [7:0] CTRL_SPLIT = 8'h85;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_RD1  = 2'd1,
    SEQ_RD2  = 2'd2,
    SEQ_OPEN = 2'd3
  } seq_state_e;

  // Offsets that the open window claims from the drive path
  function automatic logic is_hidden(input logic [OFF_W-1:0] off);
    return (off == OFF_TIM_RD) || (off == OFF_TIM_WR) || (off == OFF_CTRL) ||
           (off == OFF_STRAP)  || (off == OFF_MISC);
  endfunction

  // Unlock sequencer step for one in-range access
  function automatic seq_state_e seq_step(input seq_state_e s, input logic wr,
                                          input logic wide, input logic [OFF_W-1:0] off,
                                          input logic [7:0] wb);
    logic rd_step;
    logic key_step;
    rd_step  = !wr && wide && (off == 3'd1);
    key_step = wr && !wide && (off == OFF_KEY) && (wb == KEY_OPEN);
    case (s)
      SEQ_IDLE: return rd_step ? SEQ_RD1 : SEQ_IDLE;
      SEQ_RD1:  return rd_step ? SEQ_RD2 : SEQ_IDLE;
      SEQ_RD2:  return key_step ? SEQ_OPEN : SEQ_IDLE;
      default:  return (wr && (off == OFF_KEY) && (wb == KEY_CLOSE)) ? SEQ_IDLE : SEQ_OPEN;
    endcase
  endfunction

  // Bank a drive runs from, given the control setting
  function automatic logic [BANK_W-1:0] drive_bank(input int drv, input logic [7:0] ctrl);
    if (drv != 0 && ctrl == CTRL_SPLIT) return BANK_W'(1);
    return '0;
  endfunction

endpackage

// File: rtl/ide_cfgwin_seq.sv
module ide_cfgwin_seq
  import ide_cfgwin_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc,
  input  logic             wr,
  input  logic             wide,
  input  logic [OFF_W-1:0] off,
  input  logic [7:0]       wbyte,
  output logic             win_open,
  output logic             close_hit
);

  seq_state_e state_q;

  always_ff @(posedge clk) begin
    if (!rst_n)   state_q <= SEQ_IDLE;
    else if (acc) state_q <= seq_step(state_q, wr, wide, off, wbyte);
  end

  assign win_open  = (state_q == SEQ_OPEN);
  assign close_hit = win_open && acc && wr && (off == OFF_KEY) && (wbyte == KEY_CLOSE);

  AST_OPEN_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(win_open) |-> $past(acc && wr && !wide && off == OFF_KEY && wbyte == KEY_OPEN)); // R2

  AST_CLOSE_ON_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    close_hit |=> !win_open); // R4

  AST_ABORT_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && state_q == SEQ_RD1 && !(!wr && wide && off == 3'd1)) |=> state_q == SEQ_IDLE); // R3

endmodule

// File: rtl/ide_cfgwin_regs.sv
module ide_cfgwin_regs
  import ide_cfgwin_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [OFF_W-1:0] cfg_off,
  input  logic [REG_W-1:0] cfg_wdata,
  input  logic             strap_clk25,
  output logic [REG_W-1:0] cfg_rdata,
  output logic [REG_W-1:0] drv_rd_tim [NUM_DRV],
  output logic [REG_W-1:0] drv_wr_tim [NUM_DRV],
  output logic [REG_W-1:0] misc_out
);

  logic [NUM_BANKS-1:0][REG_W-1:0] tim_rd_q;
  logic [NUM_BANKS-1:0][REG_W-1:0] tim_wr_q;
  logic [REG_W-1:0]                ctrl_q;
  logic [REG_W-1:0]                misc_q;
  logic [BANK_W-1:0]               bank_sel;

  assign bank_sel = misc_q[BANK_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tim_rd_q <= '0;
      tim_wr_q <= '0;
      ctrl_q   <= '0;
      misc_q   <= '0;
    end else if (cfg_we) begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (bank_sel == BANK_W'(b)) begin
          if (cfg_off == OFF_TIM_RD) tim_rd_q[b] <= cfg_wdata;
          if (cfg_off == OFF_TIM_WR) tim_wr_q[b] <= cfg_wdata;
        end
      end
      if (cfg_off == OFF_CTRL) ctrl_q <= cfg_wdata;
      if (cfg_off == OFF_MISC) misc_q <= cfg_wdata;
    end
  end

  always_comb begin
    case (cfg_off)
      OFF_TIM_RD: cfg_rdata = tim_rd_q[bank_sel];
      OFF_TIM_WR: cfg_rdata = tim_wr_q[bank_sel];
      OFF_CTRL:   cfg_rdata = ctrl_q;
      OFF_STRAP:  cfg_rdata = {{(REG_W-1){1'b0}}, strap_clk25};
      OFF_MISC:   cfg_rdata = misc_q;
      default:    cfg_rdata = '0;
    endcase
  end

  for (genvar d = 0; d < NUM_DRV; d++) begin : g_drv
    logic [BANK_W-1:0] bank_d;
    assign bank_d        = drive_bank(d, ctrl_q);
    assign drv_rd_tim[d] = tim_rd_q[bank_d];
    assign drv_wr_tim[d] = tim_wr_q[bank_d];
  end

  assign misc_out = misc_q;

  logic [2*NUM_BANKS*REG_W+2*REG_W-1:0] snap;
  assign snap = {tim_rd_q, tim_wr_q, ctrl_q, misc_q};

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(snap)); // R5

  AST_STRAP_RO: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_off == OFF_STRAP) |=> $stable(snap)); // R8

  AST_BANK_A_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_off == OFF_TIM_RD && bank_sel == '0) |=> $stable(tim_rd_q[1])); // R7

endmodule

// File: rtl/ide_cfgwin.sv
module ide_cfgwin
  import ide_cfgwin_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter int                DATA_W    = 16,
  parameter int                REG_W     = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h01F0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_valid,
  input  logic              io_write,
  input  logic              io_wide,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [REG_W-1:0]  io_wbyte,
  output logic [DATA_W-1:0] io_rdata,
  output logic              drv_sel,
  input  logic [DATA_W-1:0] drv_rdata,
  input  logic              strap_clk25,
  output logic              window_open,
  output logic [REG_W-1:0]  d0_rd_tim,
  output logic [REG_W-1:0]  d0_wr_tim,
  output logic [REG_W-1:0]  d1_rd_tim,
  output logic [REG_W-1:0]  d1_wr_tim,
  output logic [REG_W-1:0]  misc_cfg
);

  localparam int PAD_W = DATA_W - REG_W;

  logic             chan_hit;
  logic             acc;
  logic [OFF_W-1:0] off;
  logic             cfg_hit;
  logic             cfg_we;
  logic             close_hit;
  logic [REG_W-1:0] cfg_rdata;
  logic [REG_W-1:0] rd_tim [NUM_DRV];
  logic [REG_W-1:0] wr_tim [NUM_DRV];

  assign chan_hit = (io_addr[ADDR_W-1:OFF_W] == BASE_ADDR[ADDR_W-1:OFF_W]);
  assign acc      = io_valid && chan_hit;
  assign off      = io_addr[OFF_W-1:0];

  ide_cfgwin_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc       (acc),
    .wr        (io_write),
    .wide      (io_wide),
    .off       (off),
    .wbyte     (io_wbyte),
    .win_open  (window_open),
    .close_hit (close_hit)
  );

  assign cfg_hit = window_open && acc && is_hidden(off);
  assign cfg_we  = cfg_hit && io_write;
  assign drv_sel = acc && !cfg_hit && !close_hit;

  ide_cfgwin_regs #(.REG_W(REG_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we      (cfg_we),
    .cfg_off     (off),
    .cfg_wdata   (io_wbyte),
    .strap_clk25 (strap_clk25),
    .cfg_rdata   (cfg_rdata),
    .drv_rd_tim  (rd_tim),
    .drv_wr_tim  (wr_tim),
    .misc_out    (misc_cfg)
  );

  assign io_rdata  = (cfg_hit && !io_write) ? {{PAD_W{1'b0}}, cfg_rdata} : drv_rdata;
  assign d0_rd_tim = rd_tim[0];
  assign d0_wr_tim = wr_tim[0];
  assign d1_rd_tim = rd_tim[1];
  assign d1_wr_tim = wr_tim[1];

  AST_CLOSED_FORWARDS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !window_open) |-> drv_sel); // R5

  AST_OUTSIDE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (io_valid && !chan_hit) |-> !drv_sel); // R11

  AST_HIDDEN_CLAIMED: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && window_open && is_hidden(off)) |-> !drv_sel); // R6

endmodule

// File: tb/ide_cfgwin_tb_top.sv
module ide_cfgwin_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_valid = 1'b0;
  logic        io_write = 1'b0;
  logic        io_wide = 1'b0;
  logic [15:0] io_addr = 16'h0;
  logic [7:0]  io_wbyte = 8'h0;
  logic [15:0] io_rdata;
  logic        drv_sel;
  logic [15:0] drv_rdata;
  logic        strap_clk25 = 1'b1;
  logic        window_open;
  logic [7:0]  d0_rd_tim, d0_wr_tim, d1_rd_tim, d1_wr_tim, misc_cfg;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #5 clk = ~clk;

  assign drv_rdata = {8'hDD, io_addr[7:0]};

  ide_cfgwin dut_i (
    .clk(clk), .rst_n(rst_n), .io_valid(io_valid), .io_write(io_write),
    .io_wide(io_wide), .io_addr(io_addr), .io_wbyte(io_wbyte),
    .io_rdata(io_rdata), .drv_sel(drv_sel), .drv_rdata(drv_rdata),
    .strap_clk25(strap_clk25), .window_open(window_open),
    .d0_rd_tim(d0_rd_tim), .d0_wr_tim(d0_wr_tim), .d1_rd_tim(d1_rd_tim),
    .d1_wr_tim(d1_wr_tim), .misc_cfg(misc_cfg)
  );

  typedef struct {
    bit          chk_rd;
    logic [15:0] exp_rd;
    logic        exp_drv;
    string       tag;
  } item_t;

  item_t sb_q[$];

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: compares each access result while it is on the bus
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        chk({it.tag, " drv_sel"}, {15'h0, drv_sel}, {15'h0, it.exp_drv});
        if (it.chk_rd) chk({it.tag, " rdata"}, io_rdata, it.exp_rd);
      end
    end
  end

  // Driver: one host cycle, expectation pushed to the scoreboard
  task automatic access(input bit wr, input bit wide, input logic [15:0] addr,
                        input logic [7:0] wb, input bit chk_rd, input logic [15:0] exp_rd,
                        input bit exp_drv, input string tag);
    item_t it;
    @(negedge clk);
    io_valid = 1'b1; io_write = wr; io_wide = wide; io_addr = addr; io_wbyte = wb;
    it.chk_rd = chk_rd; it.exp_rd = exp_rd; it.exp_drv = exp_drv; it.tag = tag;
    sb_q.push_back(it);
    @(posedge clk);
    #1 io_valid = 1'b0;
  endtask

  function automatic logic [15:0] pt(input logic [15:0] a);
    return {8'hDD, a[7:0]};
  endfunction

  task automatic cfg_rd(input logic [2:0] off, input logic [7:0] exp, input string tag);
    access(1'b0, 1'b0, 16'h01F0 + 16'(off), 8'h00, 1'b1, {8'h00, exp}, 1'b0, tag);
  endtask

  task automatic cfg_wr(input logic [2:0] off, input logic [7:0] val, input string tag);
    access(1'b1, 1'b0, 16'h01F0 + 16'(off), val, 1'b0, 16'h0, 1'b0, tag);
  endtask

  task automatic unlock(input string tag);
    access(1'b0, 1'b1, 16'h01F1, 8'h00, 1'b1, pt(16'h01F1), 1'b1, tag);
    access(1'b0, 1'b1, 16'h01F1, 8'h00, 1'b1, pt(16'h01F1), 1'b1, tag);
    access(1'b1, 1'b0, 16'h01F2, 8'h03, 1'b0, 16'h0, 1'b1, tag);
  endtask

  task automatic lock(input string tag);
    access(1'b1, 1'b0, 16'h01F2, 8'h83, 1'b0, 16'h0, 1'b0, tag);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 window", {15'h0, window_open}, 16'h0);
    chk("R1 d0_rd", {8'h0, d0_rd_tim}, 16'h0);
    chk("R1 d1_wr", {8'h0, d1_wr_tim}, 16'h0);
    chk("R1 misc", {8'h0, misc_cfg}, 16'h0);

    // R5 closed window forwards, writes do not touch settings
    access(1'b0, 1'b1, 16'h01F0, 8'h00, 1'b1, pt(16'h01F0), 1'b1, "R5 closed rd0");
    access(1'b1, 1'b0, 16'h01F0, 8'h77, 1'b0, 16'h0, 1'b1, "R5 closed wr0");
    access(1'b1, 1'b0, 16'h01F6, 8'h5A, 1'b0, 16'h0, 1'b1, "R5 closed wr6");
    #1 chk("R5 misc untouched", {8'h0, misc_cfg}, 16'h0);

    // R2 unlock
    unlock("R2 unlock");
    #1 chk("R2 open", {15'h0, window_open}, 16'h1);
    cfg_rd(3'd0, 8'h00, "R5 timing A untouched");
    cfg_rd(3'd6, 8'h00, "R1 misc bank A");

    // R7 banked timing
    cfg_wr(3'd0, 8'h5B, "R7 wr A rd");
    cfg_wr(3'd1, 8'h45, "R7 wr A wr");
    cfg_wr(3'd6, 8'h01, "R7 select B");
    cfg_wr(3'd0, 8'h48, "R7 wr B rd");
    cfg_wr(3'd1, 8'h34, "R7 wr B wr");
    cfg_rd(3'd0, 8'h48, "R7 rd B rd");
    #1 chk("R9 d1 uses A before split", {8'h0, d1_rd_tim}, 16'h005B);
    cfg_wr(3'd6, 8'hA2, "R10 misc A2");
    #1 chk("R10 misc_cfg", {8'h0, misc_cfg}, 16'h00A2);
    cfg_rd(3'd0, 8'h5B, "R7 rd A rd");
    cfg_rd(3'd1, 8'h45, "R7 rd A wr");

    // R9 split
    cfg_wr(3'd3, 8'h85, "R9 ctrl split");
    cfg_rd(3'd3, 8'h85, "R9 ctrl readback");
    #1;
    chk("R9 d0_rd", {8'h0, d0_rd_tim}, 16'h005B);
    chk("R9 d0_wr", {8'h0, d0_wr_tim}, 16'h0045);
    chk("R9 d1_rd", {8'h0, d1_rd_tim}, 16'h0048);
    chk("R9 d1_wr", {8'h0, d1_wr_tim}, 16'h0034);

    // R6 unclaimed offsets still reach the drive
    access(1'b0, 1'b1, 16'h01F4, 8'h00, 1'b1, pt(16'h01F4), 1'b1, "R6 off4 forwarded");
    access(1'b0, 1'b1, 16'h01F7, 8'h00, 1'b1, pt(16'h01F7), 1'b1, "R6 off7 forwarded");
    access(1'b1, 1'b0, 16'h01F2, 8'h10, 1'b0, 16'h0, 1'b1, "R6 off2 forwarded");
    #1 chk("R6 still open", {15'h0, window_open}, 16'h1);

    // R8 strap
    cfg_rd(3'd5, 8'h01, "R8 strap 25MHz");
    cfg_wr(3'd5, 8'hFE, "R8 strap write");
    cfg_rd(3'd5, 8'h01, "R8 strap after write");
    strap_clk25 = 1'b0;
    cfg_rd(3'd5, 8'h00, "R8 strap 33MHz");
    #1 chk("R8 misc after strap write", {8'h0, misc_cfg}, 16'h00A2);

    // R4 close
    lock("R4 close absorbed");
    #1 chk("R4 closed", {15'h0, window_open}, 16'h0);
    access(1'b0, 1'b1, 16'h01F0, 8'h00, 1'b1, pt(16'h01F0), 1'b1, "R5 rd0 after close");
    access(1'b1, 1'b0, 16'h01F0, 8'h11, 1'b0, 16'h0, 1'b1, "R5 wr0 after close");
    #1 chk("R5 d0_rd kept", {8'h0, d0_rd_tim}, 16'h005B);

    // R3 aborted handshakes
    access(1'b0, 1'b1, 16'h01F1, 8'h00, 1'b1, pt(16'h01F1), 1'b1, "R3 one read");
    access(1'b1, 1'b0, 16'h01F2, 8'h03, 1'b0, 16'h0, 1'b1, "R3 key early");
    #1 chk("R3 one read only", {15'h0, window_open}, 16'h0);
    access(1'b0, 1'b1, 16'h01F1, 8'h00, 1'b0, 16'h0, 1'b1, "R3 a");
    access(1'b0, 1'b1, 16'h01F1, 8'h00, 1'b0, 16'h0, 1'b1, "R3 a");
    access(1'b0, 1'b1, 16'h01F3, 8'h00, 1'b0, 16'h0, 1'b1, "R3 other offset");
    access(1'b1, 1'b0, 16'h01F2, 8'h03, 1'b0, 16'h0, 1'b1, "R3 key");
    #1 chk("R3 other offset aborts", {15'h0, window_open}, 16'h0);
    access(1'b0, 1'b1, 16'h01F1, 8'h00, 1'b0, 16'h0, 1'b1, "R3 b");
    access(1'b0, 1'b1, 16'h01F1, 8'h00, 1'b0, 16'h0, 1'b1, "R3 b");
    access(1'b0, 1'b1, 16'h01F1, 8'h00, 1'b0, 16'h0, 1'b1, "R3 third read");
    access(1'b1, 1'b0, 16'h01F2, 8'h03, 1'b0, 16'h0, 1'b1, "R3 key");
    #1 chk("R3 third read aborts", {15'h0, window_open}, 16'h0);
    access(1'b0, 1'b1, 16'h01F1, 8'h00, 1'b0, 16'h0, 1'b1, "R3 c");
    access(1'b0, 1'b1, 16'h01F1, 8'h00, 1'b0, 16'h0, 1'b1, "R3 c");
    access(1'b1, 1'b0, 16'h01F2, 8'h04, 1'b0, 16'h0, 1'b1, "R3 wrong key");
    access(1'b1, 1'b0, 16'h01F2, 8'h03, 1'b0, 16'h0, 1'b1, "R3 key late");
    #1 chk("R3 wrong key aborts", {15'h0, window_open}, 16'h0);

    // R11 outside range is ignored, also mid-handshake
    access(1'b0, 1'b1, 16'h0170, 8'h00, 1'b0, 16'h0, 1'b0, "R11 outside not forwarded");
    access(1'b0, 1'b1, 16'h01F1, 8'h00, 1'b0, 16'h0, 1'b1, "R11 d");
    access(1'b0, 1'b1, 16'h01F1, 8'h00, 1'b0, 16'h0, 1'b1, "R11 d");
    access(1'b0, 1'b1, 16'h0171, 8'h00, 1'b0, 16'h0, 1'b0, "R11 outside mid-handshake");
    access(1'b1, 1'b0, 16'h01F2, 8'h03, 1'b0, 16'h0, 1'b1, "R11 key");
    #1 chk("R11 open despite outside access", {15'h0, window_open}, 16'h1);
    cfg_rd(3'd3, 8'h85, "R6 ctrl kept across close");
    lock("R4 close again");
    #1 chk("R4 closed again", {15'h0, window_open}, 16'h0);

    repeat (3) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule